// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

A per-processor countdown timer. Software uses a small register bus to set a clock divide ratio, a timer entry (interrupt vector, mask, periodic/one-shot mode) and an initial count. Writing the initial count loads a 32-bit down-counter and starts it. The counter steps once per divided clock tick. When it runs out, the block emits a single-cycle interrupt request together with the programmed vector, unless the entry is masked.

In periodic mode the counter reloads from the initial count and keeps running. In one-shot mode it stops at zero. The live count can be read at any time through a read-only address. Prioritising the request against other sources and delivering it to the processor are handled elsewhere.

Register map (2-bit word address):
- 0: timer entry. Vector in bits 7:0, mask in bit 16, periodic in bit 17.
- 1: divide code in bits 2:0.
- 2: initial count.
- 3: current count (read-only).

Top module: `local_tick_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (masked, one-shot, vector 0), the divide code reads 0, and both count registers read 0. `irq_o` is low.
- R2: A write to address 2 sets the initial count and the current count to the written value in the next cycle and restarts the divider phase. Address 3 returns the live count on `bus_rdata_o` combinationally.
- R3: Divide codes 0 to 6 give ratios 2, 4, 8, 16, 32, 64 and 128; code 7 gives ratio 1. Writing the divide code restarts the divider phase. The counter decrements once every ratio cycles.
- R4: In one-shot mode (bit 17 = 0) the step from 1 signals expiry and leaves the count at 0. The count then stays at 0 and no further request occurs until address 2 is written again.
- R5: In periodic mode (bit 17 = 1) the step from 1 signals expiry and loads the initial count, so expiries repeat every initial-count × ratio cycles.
- R6: Each expiry drives `irq_o` high for one cycle, in the cycle after the expiring tick, with `irq_vec_o` equal to the vector. If the mask bit is set at expiry, `irq_o` stays low and `irq_vec_o` keeps its previous value.
- R7: Writing an initial count of 0 stops the counter at 0 with no request.
- R8: Writes to address 3 change no register and do not disturb counting.
- R9: Addresses 0 and 1 read back the written fields at the positions given in R1 to R3, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | 8 | Vector accompanying the request |

## Verification
A cycle-level reference model is compared against the request, the vector and the live count on every clock. The timer is run in one-shot mode across all eight divide codes; this separates the ratio table and the exact cycle of each decrement. Periodic runs at ratios 1 and 16 separate a correct reload period from an off-by-one that holds zero for a tick. Masking mid-run, a zero initial count and writes to the read-only address separate suppression, stopping and ignored writes from side effects on the count.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
  localparam int ADDR_W   = 2;
  localparam int VEC_W    = 8;
  localparam int DIV_W    = 3;
  localparam int PRE_W    = 7;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  localparam logic [ADDR_W-1:0] A_ENTRY = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 2'd1;
  localparam logic [ADDR_W-1:0] A_INIT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CUR   = 2'd3;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // last phase value of the divider for a given code
  function automatic logic [PRE_W-1:0] pre_term(input logic [DIV_W-1:0] code);
    logic [PRE_W:0] full;
    if (code == {DIV_W{1'b1}}) return '0;
    full = ({{PRE_W{1'b0}}, 1'b1} << (code + 1'b1)) - 1'b1;
    return full[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/ltt_prescaler.sv
module ltt_prescaler
  import ltt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d, term;

  assign term = pre_term(code);
  assign tick = (pre_q == term);

  always_comb begin
    pre_d = pre_q + 1'b1;
    if (restart || tick) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R3
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> pre_q == '0);
endmodule

// File: rtl/ltt_regs.sv
module ltt_regs
  import ltt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output entry_t            entry,
  output logic [DIV_W-1:0]  div_code,
  output logic [CNT_W-1:0]  init_cnt,
  output logic              load,
  output logic              div_wr
);
  entry_t           entry_d;
  logic [DIV_W-1:0] div_d;
  logic [CNT_W-1:0] init_d;

  assign load   = wr && (addr == A_INIT);
  assign div_wr = wr && (addr == A_DIV);

  always_comb begin
    entry_d  = entry;
    div_d    = div_code;
    init_d   = init_cnt;
    if (wr && addr == A_ENTRY) begin
      entry_d.vector   = wdata[VEC_W-1:0];
      entry_d.mask     = wdata[MASK_BIT];
      entry_d.periodic = wdata[PER_BIT];
    end
    if (div_wr) div_d  = wdata[DIV_W-1:0];
    if (load)   init_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry    <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
      div_code <= '0;
      init_cnt <= '0;
    end else begin
      entry    <= entry_d;
      div_code <= div_d;
      init_cnt <= init_d;
    end
  end

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CUR) |=> ($stable(entry) && $stable(div_code) && $stable(init_cnt)));
endmodule

// File: rtl/ltt_counter.sv
module ltt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] init_cnt,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  logic [CNT_W-1:0] cur_d;

  always_comb begin
    cur_d  = cur;
    expire = 1'b0;
    if (load) begin
      cur_d = load_val;
    end else if (tick && cur != '0) begin
      if (cur == CNT_W'(1)) begin
        expire = 1'b1;
        cur_d  = periodic ? init_cnt : '0;
      end else begin
        cur_d = cur - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= cur_d;
  end

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val));
  // R4
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && !load) |=> cur == '0);
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && periodic && cur == CNT_W'(1) && !load) |=> cur == $past(init_cnt));
  // R3
  idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur));
endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer
  import ltt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  entry_t           entry;
  logic [DIV_W-1:0] div_code;
  logic [CNT_W-1:0] init_cnt, cur;
  logic             load, div_wr, tick, expire;
  logic             irq_d;
  logic [VEC_W-1:0] vec_d;

  ltt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .entry(entry), .div_code(div_code), .init_cnt(init_cnt), .load(load), .div_wr(div_wr)
  );

  ltt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart(load || div_wr), .code(div_code), .tick(tick)
  );

  ltt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(bus_wdata_i), .tick(tick),
    .periodic(entry.periodic), .init_cnt(init_cnt), .cur(cur), .expire(expire)
  );

  always_comb begin
    irq_d = expire && !entry.mask;
    vec_d = irq_d ? entry.vector : irq_vec_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o     <= irq_d;
      irq_vec_o <= vec_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_ENTRY: begin
        bus_rdata_o[VEC_W-1:0] = entry.vector;
        bus_rdata_o[MASK_BIT]  = entry.mask;
        bus_rdata_o[PER_BIT]   = entry.periodic;
      end
      A_DIV:   bus_rdata_o[DIV_W-1:0] = div_code;
      A_INIT:  bus_rdata_o = init_cnt;
      default: bus_rdata_o = cur;
    endcase
  end

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(entry.mask));
  // R6
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_vec_o == $past(entry.vector));
  // R7
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && bus_wdata_i == '0) |=> !irq_d);
endmodule

// File: tb/local_tick_timer_tb.sv
`timescale 1ns/1ps
module local_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  vec;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  local_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .irq_vec_o(vec)
  );

  // behavioural reference
  logic [31:0] m_cur, m_init;
  logic [7:0]  m_vec, m_vout;
  logic        m_mask, m_per, m_irq;
  logic [2:0]  m_div;
  int          m_pre;

  function automatic int ratio(input logic [2:0] c);
    return (c == 3'd7) ? 1 : (2 << c);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_init = 0; m_vec = 0; m_vout = 0;
      m_mask = 1; m_per = 0; m_irq = 0; m_div = 0; m_pre = 0;
    end else begin
      bit tk, fire;
      tk = (m_pre == ratio(m_div) - 1);
      fire = 0;
      if (wr && addr == 2'd2) m_cur = wdata;
      else if (tk && m_cur != 0) begin
        if (m_cur == 1) begin fire = 1; m_cur = m_per ? m_init : 0; end
        else m_cur = m_cur - 1;
      end
      m_pre = (tk || (wr && (addr == 2'd1 || addr == 2'd2))) ? 0 : m_pre + 1;
      m_irq = fire && !m_mask;
      if (m_irq) m_vout = m_vec;
      if (wr && addr == 2'd0) begin m_vec = wdata[7:0]; m_mask = wdata[16]; m_per = wdata[17]; end
      if (wr && addr == 2'd1) m_div = wdata[2:0];
      if (wr && addr == 2'd2) m_init = wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(cur_req, "irq", {31'b0, irq}, {31'b0, m_irq});
    chk(cur_req, "vector", {24'b0, vec}, {24'b0, m_vout});
    if (!wr && addr == 2'd3) chk(cur_req, "count", rdata, m_cur);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0; addr = 2'd3;
  endtask

  task automatic rreg(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a; #0.5;
    chk(req, "readback", rdata, exp);
    addr = 2'd3;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rreg("R1", 2'd0, 32'h0001_0000);
    rreg("R1", 2'd1, 32'h0);
    rreg("R1", 2'd2, 32'h0);
    rreg("R1", 2'd3, 32'h0);
    chk("R1", "irq", {31'b0, irq}, 32'h0);
    idle(4);

    // R9 field positions
    cur_req = "R9";
    wreg(2'd0, 32'hFFFC_FF31);
    rreg("R9", 2'd0, 32'h0000_0031);
    wreg(2'd1, 32'hFFFF_FFF3);
    rreg("R9", 2'd1, 32'h3);
    wreg(2'd1, 32'h0);

    // R2 / R4 one-shot, ratio 2
    cur_req = "R2";
    wreg(2'd2, 32'd5);
    rreg("R2", 2'd2, 32'd5);
    idle(8);
    cur_req = "R4";
    idle(20);

    // R3 every divide code, one-shot
    cur_req = "R3";
    for (int c = 0; c < 8; c++) begin
      wreg(2'd1, c);
      wreg(2'd2, 32'd3);
      idle(3 * ratio(c[2:0]) + 5);
    end

    // R5 periodic at ratio 1 and 16
    cur_req = "R5";
    wreg(2'd0, 32'h0002_0047);
    wreg(2'd1, 32'd7);
    wreg(2'd2, 32'd4);
    idle(30);
    wreg(2'd1, 32'd3);
    idle(150);

    // R6 mask during periodic run, then unmask with new vector
    cur_req = "R6";
    wreg(2'd1, 32'd7);
    wreg(2'd0, 32'h0003_0047);
    idle(20);
    wreg(2'd0, 32'h0002_00A5);
    idle(20);

    // R8 write to read-only count
    cur_req = "R8";
    wreg(2'd3, 32'h1234_5678);
    idle(12);
    rreg("R8", 2'd2, 32'd4);

    // R7 zero initial count stops
    cur_req = "R7";
    wreg(2'd2, 32'd0);
    idle(20);
    rreg("R7", 2'd3, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule